// File: doc/BRIEF.md
# Processor Status Flag Unit

This block keeps the status word of a small 8-bit accumulator processor and applies the flag effects of each instruction. It receives a flag-operation code that the decoder has already worked out. With that code come the ALU result byte and its carry and overflow, the memory operand and the accumulator for a bit-test, and a byte taken from the stack. The six live flags (negative, overflow, decimal, interrupt disable, zero, carry) are registered. Each one is also brought out as its own pin, so that branch and interrupt logic can use it.

The block also builds the byte that is written when the status is pushed. That byte adds a constant-one bit and a break bit to the six flags. The source of the push chooses the break bit. The ALU, decimal arithmetic, opcode decoding and stack addressing are handled by other blocks.

Top module: `psr_flag_unit`

## Requirements
- R1: A cycle with `rst` high sets the interrupt-disable flag to 1 and clears the decimal flag. N, V, Z and C are undefined after reset.
- R2: The single-flag codes change exactly one flag and leave the other five unchanged. The codes are: 1 clears C, 2 sets C, 3 clears I, 4 sets I, 5 clears D, 6 sets D, 7 clears V.
- R3: Code 8 is the class used by loads, transfers, increments, decrements and the logic operations. It sets N to bit 7 of `alu_res` and sets Z to 1 exactly when `alu_res` is zero. V, D, I and C stay unchanged.
- R4: Code 9 is the add and subtract class. It updates N and Z as in R3, copies `alu_carry` into C and `alu_ovf` into V, and leaves D and I unchanged.
- R5: Code 10 is the compare, shift and rotate class. It updates N and Z as in R3, copies `alu_carry` into C, and leaves V, D and I unchanged.
- R6: Code 11 is the bit-test. N takes `mem_opnd[7]` and V takes `mem_opnd[6]`. Z is set exactly when `mem_opnd & acc_val` is zero. D, I and C stay unchanged.
- R7: Code 12 restores the flags from `stk_byte`. N, V, D, I, Z and C come from bits 7, 6, 3, 2, 1 and 0. Bits 5 and 4 of the pulled byte have no effect.
- R8: `status_push` is the byte {N, V, 1, `push_brk`, D, I, Z, C} from bit 7 down to bit 0, built from the current flags. It is combinational.
- R9: Codes 0, 13, 14 and 15 change no flag.
- R10: A flag update appears on the flag outputs at the first rising edge after the code is presented. The inputs that go with the code are sampled at that same edge.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flag_op | input | 4 | Decoded flag-operation code |
| alu_res | input | 8 | ALU result byte |
| alu_carry | input | 1 | ALU carry-out |
| alu_ovf | input | 1 | ALU signed overflow |
| mem_opnd | input | 8 | Memory operand for bit-test |
| acc_val | input | 8 | Accumulator value for bit-test |
| stk_byte | input | 8 | Status byte pulled from the stack |
| push_brk | input | 1 | Break bit to place in the pushed byte |
| status_push | output | 8 | Packed status byte for a push |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_d | output | 1 | Decimal flag |
| flag_i | output | 1 | Interrupt-disable flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
Every flag update passes through exactly one register. The bench therefore drives a code and its operands on a falling edge, lets one rising edge pass, and compares all six flags on the next falling edge against a model held in the bench.

`status_push` has no register in its path. It is compared in the same sampling window for both values of `push_brk`, by changing `push_brk` and waiting a short delay before each comparison.

Right after reset only I and D are checked. A restore then puts every flag into a known state, and constrained random operations follow, mixed with directed cases:
- a zero result and a result with bit 7 set;
- a bit-test whose AND is zero;
- a pulled byte with bits 5 and 4 inverted.

// File: rtl/psr_flag_unit.sv
module psr_flag_unit #(
  parameter int OPW = 4,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] flag_op,
  input  logic [DW-1:0]  alu_res,
  input  logic           alu_carry,
  input  logic           alu_ovf,
  input  logic [DW-1:0]  mem_opnd,
  input  logic [DW-1:0]  acc_val,
  input  logic [DW-1:0]  stk_byte,
  input  logic           push_brk,
  output logic [DW-1:0]  status_push,
  output logic           flag_n,
  output logic           flag_v,
  output logic           flag_d,
  output logic           flag_i,
  output logic           flag_z,
  output logic           flag_c
);
  localparam logic [OPW-1:0] OP_CLC = OPW'(1);
  localparam logic [OPW-1:0] OP_SEC = OPW'(2);
  localparam logic [OPW-1:0] OP_CLI = OPW'(3);
  localparam logic [OPW-1:0] OP_SEI = OPW'(4);
  localparam logic [OPW-1:0] OP_CLD = OPW'(5);
  localparam logic [OPW-1:0] OP_SED = OPW'(6);
  localparam logic [OPW-1:0] OP_CLV = OPW'(7);
  localparam logic [OPW-1:0] OP_NZ  = OPW'(8);
  localparam logic [OPW-1:0] OP_ARI = OPW'(9);
  localparam logic [OPW-1:0] OP_NZC = OPW'(10);
  localparam logic [OPW-1:0] OP_BIT = OPW'(11);
  localparam logic [OPW-1:0] OP_PUL = OPW'(12);
  localparam int MSB = DW - 1;

  logic res_zero, bit_zero;
  assign res_zero = (alu_res == '0);
  assign bit_zero = ((mem_opnd & acc_val) == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_i <= 1'b1;
      flag_d <= 1'b0;
    end else begin
      unique case (flag_op)
        OP_CLC: flag_c <= 1'b0;
        OP_SEC: flag_c <= 1'b1;
        OP_CLI: flag_i <= 1'b0;
        OP_SEI: flag_i <= 1'b1;
        OP_CLD: flag_d <= 1'b0;
        OP_SED: flag_d <= 1'b1;
        OP_CLV: flag_v <= 1'b0;
        OP_NZ: begin
          flag_n <= alu_res[MSB];
          flag_z <= res_zero;
        end
        OP_ARI: begin
          flag_n <= alu_res[MSB];
          flag_z <= res_zero;
          flag_c <= alu_carry;
          flag_v <= alu_ovf;
        end
        OP_NZC: begin
          flag_n <= alu_res[MSB];
          flag_z <= res_zero;
          flag_c <= alu_carry;
        end
        OP_BIT: begin
          flag_n <= mem_opnd[7];
          flag_v <= mem_opnd[6];
          flag_z <= bit_zero;
        end
        OP_PUL: begin
          flag_n <= stk_byte[7];
          flag_v <= stk_byte[6];
          flag_d <= stk_byte[3];
          flag_i <= stk_byte[2];
          flag_z <= stk_byte[1];
          flag_c <= stk_byte[0];
        end
        default: ;
      endcase
    end
  end

  assign status_push = {flag_n, flag_v, 1'b1, push_brk, flag_d, flag_i, flag_z, flag_c};
endmodule

// File: rtl/psr_flag_unit_chk.sv
module psr_flag_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] flag_op,
  input logic [7:0] alu_res,
  input logic       alu_carry,
  input logic       alu_ovf,
  input logic [7:0] mem_opnd,
  input logic [7:0] acc_val,
  input logic [7:0] stk_byte,
  input logic       push_brk,
  input logic [7:0] status_push,
  input logic       flag_n,
  input logic       flag_v,
  input logic       flag_d,
  input logic       flag_i,
  input logic       flag_z,
  input logic       flag_c
);
  logic [5:0] fl;
  assign fl = {flag_n, flag_v, flag_d, flag_i, flag_z, flag_c};

  p_reset_r1: assert property (@(posedge clk) rst |=> (flag_i && !flag_d));

  p_sec_r2: assert property (@(posedge clk) disable iff (rst)
    (flag_op == 4'd2) |=> (flag_c && $stable({flag_n, flag_v, flag_d, flag_i, flag_z})));

  p_cli_r2: assert property (@(posedge clk) disable iff (rst)
    (flag_op == 4'd3) |=> (!flag_i && $stable({flag_n, flag_v, flag_d, flag_z, flag_c})));

  p_nz_r3: assert property (@(posedge clk) disable iff (rst)
    (flag_op == 4'd8) |=> (flag_z == ($past(alu_res) == 8'h00) && flag_n == $past(alu_res[7])
                           && $stable({flag_v, flag_d, flag_i, flag_c})));

  p_arith_r4: assert property (@(posedge clk) disable iff (rst)
    (flag_op == 4'd9) |=> (flag_c == $past(alu_carry) && flag_v == $past(alu_ovf)
                           && $stable({flag_d, flag_i})));

  p_nzc_r5: assert property (@(posedge clk) disable iff (rst)
    (flag_op == 4'd10) |=> (flag_c == $past(alu_carry) && $stable({flag_v, flag_d, flag_i})));

  p_bit_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_op == 4'd11) |=> (flag_z == (($past(mem_opnd) & $past(acc_val)) == 8'h00)
                            && flag_v == $past(mem_opnd[6]) && $stable({flag_d, flag_i, flag_c})));

  p_pull_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_op == 4'd12) |=> (fl == {$past(stk_byte[7:6]), $past(stk_byte[3:0])}));

  always_comb begin
    if (!rst) begin
      p_push_r8: assert (status_push[5] && status_push[4] == push_brk
                         && status_push[7] == flag_n && status_push[0] == flag_c);
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_op == 4'd0 || flag_op >= 4'd13) |=> $stable(fl));
endmodule

bind psr_flag_unit psr_flag_unit_chk u_chk (
  .clk(clk), .rst(rst), .flag_op(flag_op), .alu_res(alu_res), .alu_carry(alu_carry),
  .alu_ovf(alu_ovf), .mem_opnd(mem_opnd), .acc_val(acc_val), .stk_byte(stk_byte),
  .push_brk(push_brk), .status_push(status_push), .flag_n(flag_n), .flag_v(flag_v),
  .flag_d(flag_d), .flag_i(flag_i), .flag_z(flag_z), .flag_c(flag_c)
);

// File: tb/psr_flag_unit_bench.sv
`timescale 1ns/1ps
module psr_flag_unit_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] flag_op;
  logic [7:0] alu_res, mem_opnd, acc_val, stk_byte, status_push;
  logic       alu_carry, alu_ovf, push_brk;
  logic       flag_n, flag_v, flag_d, flag_i, flag_z, flag_c;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [5:0] model;

  always #4 clk = ~clk;

  psr_flag_unit u_psr_flag_unit (
    .clk(clk), .rst(rst), .flag_op(flag_op), .alu_res(alu_res), .alu_carry(alu_carry),
    .alu_ovf(alu_ovf), .mem_opnd(mem_opnd), .acc_val(acc_val), .stk_byte(stk_byte),
    .push_brk(push_brk), .status_push(status_push), .flag_n(flag_n), .flag_v(flag_v),
    .flag_d(flag_d), .flag_i(flag_i), .flag_z(flag_z), .flag_c(flag_c)
  );

  function automatic string req_of(input logic [3:0] op);
    if (op >= 4'd1 && op <= 4'd7) return "R2";
    case (op)
      4'd8:  return "R3";
      4'd9:  return "R4";
      4'd10: return "R5";
      4'd11: return "R6";
      4'd12: return "R7";
      default: return "R9";
    endcase
  endfunction

  // model bits: {N,V,D,I,Z,C}
  function automatic logic [5:0] next_flags(input logic [5:0] f, input logic [3:0] op,
      input logic [7:0] res, input logic cy, input logic ov,
      input logic [7:0] mem, input logic [7:0] acc, input logic [7:0] stk);
    logic [5:0] g = f;
    case (op)
      4'd1: g[0] = 1'b0;
      4'd2: g[0] = 1'b1;
      4'd3: g[2] = 1'b0;
      4'd4: g[2] = 1'b1;
      4'd5: g[3] = 1'b0;
      4'd6: g[3] = 1'b1;
      4'd7: g[4] = 1'b0;
      4'd8: begin g[5] = res[7]; g[1] = (res == 0); end
      4'd9: begin g[5] = res[7]; g[1] = (res == 0); g[0] = cy; g[4] = ov; end
      4'd10: begin g[5] = res[7]; g[1] = (res == 0); g[0] = cy; end
      4'd11: begin g[5] = mem[7]; g[4] = mem[6]; g[1] = ((mem & acc) == 0); end
      4'd12: g = {stk[7:6], stk[3:0]};
      default: ;
    endcase
    return g;
  endfunction

  task automatic check_all(input string req);
    logic [5:0] got = {flag_n, flag_v, flag_d, flag_i, flag_z, flag_c};
    checks++;
    if (got !== model) begin
      errors++;
      $display("FAIL %s flags {N,V,D,I,Z,C} actual=%b expected=%b", req, got, model);
    end
    for (int b = 0; b < 2; b++) begin
      logic [7:0] exp;
      push_brk = b[0];
      #1;
      exp = {model[5:4], 1'b1, b[0], model[3:0]};
      checks++;
      if (status_push !== exp) begin
        errors++;
        $display("FAIL R8 push byte actual=%h expected=%h", status_push, exp);
      end
    end
  endtask

  task automatic do_op(input logic [3:0] op, input logic [7:0] res, input logic cy,
      input logic ov, input logic [7:0] mem, input logic [7:0] acc, input logic [7:0] stk);
    flag_op = op; alu_res = res; alu_carry = cy; alu_ovf = ov;
    mem_opnd = mem; acc_val = acc; stk_byte = stk;
    model = next_flags(model, op, res, cy, ov, mem, acc, stk);
    @(posedge clk);
    @(negedge clk);
    flag_op = 4'd0;
    alu_res = ~res; mem_opnd = ~mem; stk_byte = ~stk;
    check_all($sformatf("%s/R10", req_of(op)));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; flag_op = 4'd0; alu_res = 0; alu_carry = 0; alu_ovf = 0;
    mem_opnd = 0; acc_val = 0; stk_byte = 0; push_brk = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    checks++;
    if (flag_i !== 1'b1 || flag_d !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset I,D actual=%b%b expected=10", flag_i, flag_d);
    end
    model = 6'b000000;
    // R7: pulled byte with bits 5,4 set must not leak into anything
    do_op(4'd12, 8'h00, 0, 0, 8'h00, 8'h00, 8'h30);
    do_op(4'd12, 8'h00, 0, 0, 8'h00, 8'h00, 8'hCF);
    // R2 single flags
    for (int k = 1; k <= 7; k++) do_op(k[3:0], 8'h00, 0, 0, 8'h00, 8'h00, 8'h00);
    // R3 zero and negative results
    do_op(4'd8, 8'h00, 1, 1, 8'h00, 8'h00, 8'h00);
    do_op(4'd8, 8'h80, 0, 0, 8'h00, 8'h00, 8'h00);
    // R4 / R5
    do_op(4'd9, 8'h00, 1, 1, 8'h00, 8'h00, 8'h00);
    do_op(4'd10, 8'hFF, 0, 0, 8'h00, 8'h00, 8'h00);
    // R6 AND zero while operand has bits 7,6 set
    do_op(4'd11, 8'h00, 0, 0, 8'hC0, 8'h3F, 8'h00);
    do_op(4'd11, 8'h00, 0, 0, 8'h01, 8'h01, 8'h00);
    // R9 hold codes
    do_op(4'd0, 8'h00, 1, 1, 8'hFF, 8'hFF, 8'hFF);
    do_op(4'd15, 8'h00, 1, 1, 8'hFF, 8'hFF, 8'hFF);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [3:0] op = 4'($urandom_range(0, 15));
      logic [7:0] r = 8'($urandom);
      if (($urandom & 7) == 0) r = 8'h00;
      do_op(op, r, 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    end
    // R1 again: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (flag_i !== 1'b1 || flag_d !== 1'b0) begin
      errors++;
      $display("FAIL R1 second reset I,D actual=%b%b expected=10", flag_i, flag_d);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule